// File: doc/BRIEF.md
# Suspend Write-Lock Controller

This block sits between a slow asynchronous microprocessor bus and a peripheral's register file. It samples the host strobes into the core clock domain and turns every write strobe into exactly one write command. It then decides whether that command may reach the register file. When the peripheral suspends while the host side is unpowered, the host bus lines float. To keep noise on those lines from corrupting state, the block arms a write lock. It keeps that lock after resume until firmware writes a 16-bit key to a dedicated unlock address.

The block also owns a one-byte line test control register. Its bit groups are mutually exclusive, and once a test mode has been entered it can be left only by power-on reset. A line-level bus reset leaves both the lock and the test byte untouched.

Top module: `hostwr_lock_ctrl`

## Requirements
- R1: After power-on reset (`rst` high), `locked_o` is 0, `test_mode_o` is 00h, `tm_err_o` is 0, and no `reg_we_o` or `reg_re_o` pulse appears until a strobe arrives.
- R2: A `suspend_i` pulse while `host_pwr_i` is 0 makes `locked_o` 1 on the following cycle. While locked, writes to ordinary addresses give no `reg_we_o` pulse, and writes to the test register at 84h are ignored.
- R3: A `suspend_i` pulse while `host_pwr_i` is 1 leaves `locked_o` at 0, and writes keep being forwarded.
- R4: Between an unpowered suspend and the next `resume_i` pulse, every write is ignored, including the key. After resume, writing AAh (bits 15:8) and 37h (bits 7:0) to address 7Ch clears `locked_o`.
- R5: While the block waits for the key after resume, any other data value at 7Ch, or the key at any other address, leaves `locked_o` at 1.
- R6: Each read strobe (`rd_n_i` falling while `cs_n_i` is low) gives exactly one `reg_re_o` pulse, whatever the lock state.
- R7: Each write strobe (`wr_n_i` falling while `cs_n_i` is low) to an address other than 7Ch or 84h, while unlocked, gives exactly one `reg_we_o` pulse carrying the captured address and data. Strobes made while `cs_n_i` is high give no pulse.
- R8: The test register at 84h has these bits: 7 force high-speed, 4 force full-speed, 3 pseudo-random pattern, 2 K state, 1 J state, 0 SE0/NAK. Bits 6 and 5 always read 0. A legal write loads bits 7 and 4:0 of the data.
- R9: A test-register write that sets both bit 7 and bit 4, or more than one of bits 3:0, leaves the register unchanged and sets the sticky `tm_err_o`.
- R10: While `test_mode_o` is non-zero, every further write to 84h is ignored and does not raise `tm_err_o`. Only `rst` returns the register to 00h.
- R11: A `bus_rst_i` pulse leaves `locked_o` and `test_mode_o` unchanged and clears `tm_err_o`.
- R12: Writes to 7Ch or 84h never produce a `reg_we_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| bus_rst_i | input | 1 | Line-level bus reset pulse |
| host_pwr_i | input | 1 | Host side powered mode bit |
| suspend_i | input | 1 | Suspend entry pulse |
| resume_i | input | 1 | Resume pulse |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| addr_i | input | 8 | Host address, stable while a strobe is low |
| data_i | input | 16 | Host write data, stable while a strobe is low |
| reg_we_o | output | 1 | One-cycle write command to the register file |
| reg_re_o | output | 1 | One-cycle read command to the register file |
| reg_addr_o | output | 8 | Captured address of the current command |
| reg_wdata_o | output | 16 | Captured write data of the current command |
| locked_o | output | 1 | Write lock active |
| test_mode_o | output | 8 | Line test control byte |
| tm_err_o | output | 1 | Sticky flag for a rejected test-register write |

## Verification
The hardest condition to reach from the ports is the key-wait state, and above all its boundary with the asleep state. There a correct key must still be refused, because no resume pulse has been seen yet. The stimulus reaches it with a directed sequence: an unpowered suspend, a key write, a resume, two near-miss keys and then the true key. After that, a seeded random mix of suspends, resumes, key attempts, test-register patterns and resets crosses these states many more times under both power settings. The test register freezes after its first legal write, so the random mix also issues occasional power-on resets to reopen it.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int TM_W   = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h7C;
    localparam logic [ADDR_W-1:0] TMODE_ADDR  = 8'h84;
    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 16'hAA37;

    localparam int TM_FHS  = 7;
    localparam int TM_FFS  = 4;
    localparam int TM_PRBS = 3;
    localparam int TM_K    = 2;
    localparam int TM_J    = 1;
    localparam int TM_SE0  = 0;
    localparam logic [TM_W-1:0] TM_KEEP_MASK = 8'b1001_1111;

    typedef enum logic [1:0] {
        LK_OPEN     = 2'd0,
        LK_ASLEEP   = 2'd1,
        LK_WAIT_KEY = 2'd2
    } lock_st_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hcmd_t;

    function automatic logic [TM_W-1:0] tm_clean(input logic [TM_W-1:0] v);
        return v & TM_KEEP_MASK;
    endfunction

    function automatic logic tm_legal(input logic [TM_W-1:0] v);
        logic speed_clash;
        int   line_cnt;
        speed_clash = v[TM_FHS] & v[TM_FFS];
        line_cnt = int'(v[TM_PRBS]) + int'(v[TM_K]) + int'(v[TM_J]) + int'(v[TM_SE0]);
        return !speed_clash && (line_cnt <= 1);
    endfunction

    function automatic logic is_key_write(input hcmd_t c);
        return c.wr && (c.addr == UNLOCK_ADDR) && (c.data == UNLOCK_KEY);
    endfunction
endpackage

// File: rtl/hwl_sync.sv
module hwl_sync
    import hwl_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output hcmd_t             cmd
);
    localparam int NSTROBE = 3;
    localparam int LAST    = STAGES - 1;
    localparam int IDX_CS  = 0;
    localparam int IDX_WR  = 1;
    localparam int IDX_RD  = 2;

    logic [NSTROBE-1:0] raw_n;
    logic [NSTROBE-1:0] synced_n;
    logic [NSTROBE-1:0] prev_n;
    logic               wr_fall;
    logic               rd_fall;

    assign raw_n = {rd_n, wr_n, cs_n};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_chain
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh        <= '1;
                prev_n[g] <= 1'b1;
            end else begin
                sh        <= {sh[LAST-1:0], raw_n[g]};
                prev_n[g] <= sh[LAST];
            end
        end
        assign synced_n[g] = sh[LAST];
    end

    assign wr_fall = !synced_n[IDX_WR] && prev_n[IDX_WR] && !synced_n[IDX_CS];
    assign rd_fall = !synced_n[IDX_RD] && prev_n[IDX_RD] && !synced_n[IDX_CS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else begin
            cmd.wr <= wr_fall;
            cmd.rd <= rd_fall;
            if (wr_fall || rd_fall) begin
                cmd.addr <= addr;
                cmd.data <= data;
            end
        end
    end
endmodule

// File: rtl/hwl_lock.sv
module hwl_lock
    import hwl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     suspend,
    input  logic     resume,
    input  logic     host_pwr,
    input  hcmd_t    cmd,
    output lock_st_e st,
    output logic     wr_open
);
    lock_st_e st_nx;
    logic     arm;

    assign arm = suspend && !host_pwr;

    always_comb begin
        st_nx = st;
        unique case (st)
            LK_OPEN:     if (arm) st_nx = LK_ASLEEP;
            LK_ASLEEP:   if (resume) st_nx = LK_WAIT_KEY;
            LK_WAIT_KEY: begin
                if (arm)                    st_nx = LK_ASLEEP;
                else if (is_key_write(cmd)) st_nx = LK_OPEN;
            end
            default:     st_nx = LK_ASLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= LK_OPEN;
        else     st <= st_nx;
    end

    assign wr_open = (st == LK_OPEN);
endmodule

// File: rtl/hwl_tmode.sv
module hwl_tmode
    import hwl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_rst,
    input  logic            wr_en,
    input  logic [TM_W-1:0] wdata,
    output logic [TM_W-1:0] tm,
    output logic            err
);
    logic frozen;

    assign frozen = (tm != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tm  <= '0;
            err <= 1'b0;
        end else begin
            if (bus_rst) err <= 1'b0;
            if (wr_en && !frozen) begin
                if (tm_legal(wdata)) tm  <= tm_clean(wdata);
                else                 err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hostwr_lock_ctrl.sv
module hostwr_lock_ctrl
    import hwl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rst_i,
    input  logic        host_pwr_i,
    input  logic        suspend_i,
    input  logic        resume_i,
    input  logic        cs_n_i,
    input  logic        wr_n_i,
    input  logic        rd_n_i,
    input  logic [7:0]  addr_i,
    input  logic [15:0] data_i,
    output logic        reg_we_o,
    output logic        reg_re_o,
    output logic [7:0]  reg_addr_o,
    output logic [15:0] reg_wdata_o,
    output logic        locked_o,
    output logic [7:0]  test_mode_o,
    output logic        tm_err_o
);
    hcmd_t    cmd;
    lock_st_e lk_st;
    logic     wr_open;
    logic     local_addr;
    logic     tm_wr;

    hwl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n_i),
        .wr_n (wr_n_i),
        .rd_n (rd_n_i),
        .addr (addr_i),
        .data (data_i),
        .cmd  (cmd)
    );

    hwl_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .suspend  (suspend_i),
        .resume   (resume_i),
        .host_pwr (host_pwr_i),
        .cmd      (cmd),
        .st       (lk_st),
        .wr_open  (wr_open)
    );

    assign local_addr = (cmd.addr == UNLOCK_ADDR) || (cmd.addr == TMODE_ADDR);
    assign tm_wr      = cmd.wr && wr_open && (cmd.addr == TMODE_ADDR);

    hwl_tmode u_tmode (
        .clk     (clk),
        .rst     (rst),
        .bus_rst (bus_rst_i),
        .wr_en   (tm_wr),
        .wdata   (cmd.data[TM_W-1:0]),
        .tm      (test_mode_o),
        .err     (tm_err_o)
    );

    assign reg_we_o    = cmd.wr && wr_open && !local_addr;
    assign reg_re_o    = cmd.rd;
    assign reg_addr_o  = cmd.addr;
    assign reg_wdata_o = cmd.data;
    assign locked_o    = (lk_st != LK_OPEN);
endmodule

// File: rtl/hwl_checker.sv
module hwl_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_rst_i,
    input logic       host_pwr_i,
    input logic       suspend_i,
    input logic       reg_we_o,
    input logic [7:0] reg_addr_o,
    input logic       locked_o,
    input logic [7:0] test_mode_o,
    input logic       tm_err_o
);
    assert_arm_unpowered_R2: assert property (@(posedge clk) disable iff (rst)
        (suspend_i && !host_pwr_i) |=> locked_o);

    assert_stay_open_R3: assert property (@(posedge clk) disable iff (rst)
        (!locked_o && !(suspend_i && !host_pwr_i)) |=> !locked_o);

    assert_no_fwd_locked_R2: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> !locked_o);

    assert_local_hidden_R12: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> (reg_addr_o != 8'h7C && reg_addr_o != 8'h84));

    assert_tm_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones({test_mode_o[7], test_mode_o[4]}) <= 1) &&
        ($countones(test_mode_o[3:0]) <= 1) && (test_mode_o[6:5] == 2'b00));

    assert_tm_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (test_mode_o != 8'h00) |=> $stable(test_mode_o));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (tm_err_o && !bus_rst_i) |=> tm_err_o);
endmodule

bind hostwr_lock_ctrl hwl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rst_i   (bus_rst_i),
    .host_pwr_i  (host_pwr_i),
    .suspend_i   (suspend_i),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .locked_o    (locked_o),
    .test_mode_o (test_mode_o),
    .tm_err_o    (tm_err_o)
);

// File: tb/hostwr_lock_ctrl_test.sv
module hostwr_lock_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst_i = 1'b0;
    logic        host_pwr_i = 1'b1;
    logic        suspend_i = 1'b0;
    logic        resume_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        wr_n_i = 1'b1;
    logic        rd_n_i = 1'b1;
    logic [7:0]  addr_i = '0;
    logic [15:0] data_i = '0;
    logic        reg_we_o, reg_re_o, locked_o, tm_err_o;
    logic [7:0]  reg_addr_o, test_mode_o;
    logic [15:0] reg_wdata_o;

    int vectors = 0;
    int misses  = 0;
    int we_cnt  = 0;
    int re_cnt  = 0;
    logic [7:0]  last_a;
    logic [15:0] last_d;
    bit done = 0;

    // model state: 0 open, 1 asleep, 2 waiting for key
    int         m_st  = 0;
    logic [7:0] m_tm  = 0;
    bit         m_err = 0;

    always #5 clk = ~clk;

    hostwr_lock_ctrl uut (.*);

    always @(posedge clk) begin
        if (reg_we_o) begin
            we_cnt <= we_cnt + 1;
            last_a <= reg_addr_o;
            last_d <= reg_wdata_o;
        end
        if (reg_re_o) re_cnt <= re_cnt + 1;
    end

    function automatic bit f_legal(input logic [7:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 4; i++) if (v[i]) n++;
        return !(v[7] && v[4]) && (n <= 1);
    endfunction

    function automatic logic [7:0] f_clean(input logic [7:0] v);
        return {v[7], 2'b00, v[4:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(locked_o == (m_st != 0), {req, " lock"}, int'(locked_o), int'(m_st != 0));
        check(test_mode_o == m_tm, {req, " tmode"}, int'(test_mode_o), int'(m_tm));
        check(tm_err_o == m_err, {req, " err"}, int'(tm_err_o), int'(m_err));
    endtask

    task automatic do_por();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_tm = 0; m_err = 0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit cs_on, input string req);
        int  w0;
        bit  fwd;
        w0 = we_cnt;
        @(negedge clk);
        addr_i = a; data_i = d; cs_n_i = !cs_on;
        @(negedge clk);
        wr_n_i = 1'b0;
        repeat (5) @(negedge clk);
        wr_n_i = 1'b1;
        @(negedge clk);
        cs_n_i = 1'b1;
        repeat (4) @(negedge clk);
        fwd = cs_on && (m_st == 0) && (a != 8'h7C) && (a != 8'h84);
        if (cs_on) begin
            if (a == 8'h7C && d == 16'hAA37 && m_st == 2) m_st = 0;
            else if (a == 8'h84 && m_st == 0 && m_tm == 0) begin
                if (f_legal(d[7:0])) m_tm = f_clean(d[7:0]);
                else m_err = 1;
            end
        end
        check((we_cnt - w0) == int'(fwd), {req, " we count"}, we_cnt - w0, int'(fwd));
        if (fwd) begin
            check(last_a == a, {req, " addr"}, int'(last_a), int'(a));
            check(last_d == d, {req, " data"}, int'(last_d), int'(d));
        end
        check_state(req);
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        int r0;
        r0 = re_cnt;
        @(negedge clk);
        addr_i = a; cs_n_i = 1'b0;
        @(negedge clk);
        rd_n_i = 1'b0;
        repeat (5) @(negedge clk);
        rd_n_i = 1'b1;
        @(negedge clk);
        cs_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check((re_cnt - r0) == 1, {req, " re count"}, re_cnt - r0, 1);
    endtask

    task automatic do_pulse(input int which, input string req);
        @(negedge clk);
        case (which)
            0: suspend_i = 1'b1;
            1: resume_i  = 1'b1;
            default: bus_rst_i = 1'b1;
        endcase
        @(negedge clk);
        suspend_i = 1'b0; resume_i = 1'b0; bus_rst_i = 1'b0;
        case (which)
            0: if (!host_pwr_i && m_st != 1) m_st = 1;
            1: if (m_st == 1) m_st = 2;
            default: m_err = 0;
        endcase
        @(negedge clk);
        check_state(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1583));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        check(we_cnt == 0 && re_cnt == 0, "R1 no pulses", we_cnt + re_cnt, 0);

        do_write(8'h10, 16'h1234, 1, "R7 plain write");
        do_write(8'h11, 16'h5555, 0, "R7 cs high");
        host_pwr_i = 1'b1;
        do_pulse(0, "R3 powered suspend");
        do_write(8'h12, 16'hBEEF, 1, "R3 write after powered suspend");
        host_pwr_i = 1'b0;
        do_pulse(0, "R2 unpowered suspend");
        do_write(8'h20, 16'hCAFE, 1, "R2 blocked write");
        do_read(8'h20, "R6 read while locked");
        do_write(8'h7C, 16'hAA37, 1, "R4 key while asleep");
        do_pulse(1, "R4 resume");
        do_write(8'h7C, 16'hAA38, 1, "R5 wrong key");
        do_write(8'h7D, 16'hAA37, 1, "R5 wrong addr");
        do_write(8'h84, 16'h0001, 1, "R2 tmode while locked");
        do_write(8'h7C, 16'hAA37, 1, "R4 correct key");
        do_write(8'h7C, 16'h0000, 1, "R12 unlock addr");
        do_write(8'h84, 16'h0000, 1, "R12 tmode addr");
        do_write(8'h84, 16'h0090, 1, "R9 speed clash");
        do_write(8'h84, 16'h0006, 1, "R9 line clash");
        do_pulse(2, "R11 bus reset clears err");
        do_write(8'h84, 16'h0061, 1, "R8 reserved masked");
        do_write(8'h84, 16'h0084, 1, "R10 frozen");
        do_write(8'h84, 16'h0090, 1, "R10 no err when frozen");
        do_pulse(0, "R2 relock");
        do_pulse(2, "R11 bus reset keeps lock");
        do_por();
        check_state("R10 por clears");
        do_write(8'h84, 16'h0084, 1, "R8 legal pair");

        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 11));
            host_pwr_i = $urandom_range(0, 1) == 1;
            case (op)
                0, 1: do_write(8'($urandom_range(0, 255)), 16'($urandom), 1, "R7 random write");
                2:    do_write(8'h7C, ($urandom_range(0, 1) == 1) ? 16'hAA37 : 16'($urandom), 1, "R5 random key");
                3, 4: do_write(8'h84, 16'($urandom_range(0, 255)), 1, "R9 random tmode");
                5:    do_write(8'($urandom_range(0, 255)), 16'($urandom), 0, "R7 random cs high");
                6:    do_read(8'($urandom_range(0, 255)), "R6 random read");
                7, 8: do_pulse(0, "R2 random suspend");
                9:    do_pulse(1, "R4 random resume");
                10:   do_pulse(2, "R11 random bus reset");
                default: begin
                    do_por();
                    check_state("R1 random por");
                end
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule